// File: doc/BRIEF.md
# Second-Order Noise-Shaping Truncator with Thermometer Drive

This block takes a wide, static or slowly moving control word and turns it into a coarse 4-bit level stream. Over time, the average of that stream equals the word scaled down to the 4-bit range. The truncation error is shaped by a second-order error-feedback loop whose noise transfer is (1 − z⁻¹)². The error energy is pushed toward high frequency, where an analog low-pass after the unit cells removes it. Each coarse level is expanded into 15 thermometer lines, one per unit current cell, and both forms leave the block from registers.

A chip uses two copies of the block: one carries the frequency-loop word and one carries the integral-path word. The input is a plain control pin, sampled on every rising clock edge. The outputs update every cycle and have no handshake. The loads are current cells that accept a new code on every edge, so there is nothing to apply back-pressure to.

Top module: `dsm2_therm_dac`

## Requirements
- R1: `rst` is synchronous and active high. After any edge at which `rst` is high, `level` is 0, all `therm` lines are low and both stored error terms are zero. The stream that follows reset is therefore identical to the stream from power-up for the same input sequence.
- R2: `level` and `therm` are registered. They reflect the `ctrl_word` sampled at the previous rising edge, so the latency is one cycle.
- R3: Each cycle the block forms the sum s[n] = x[n] + 2·e[n−1] − e[n−2], where x is the unsigned `ctrl_word`. It then stores the error e[n] = s[n] − 1024·level[n].
- R4: When 0 ≤ s ≤ 16383, `level` is floor(s / 1024), which is bits 13 down to 10 of s. The error is the low 10 bits of s, in the range 0..1023.
- R5: When s > 16383, `level` saturates to 15. When s < 0, `level` saturates to 0. In both cases the stored error is the full difference s − 1024·level.
- R6: Thermometer bit k (bit 0 is the least significant) is high exactly when `level` > k, for k = 0..14.
- R7: The high lines of `therm` always form an unbroken run starting at bit 0, with no high bit above a low bit.
- R8: Start from reset and hold `ctrl_word` constant at 0 or at any value from 1023 to 14337. The sum of `level` over the first 1024 output cycles then lies within ±1 of `ctrl_word`, so the mean equals input/1024 within 1/1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Unsigned control word to be truncated |
| level | output | 4 | Registered coarse level, 0..15 |
| therm | output | 15 | Registered thermometer lines, bit k high when level > k |

## Verification
The stimulus uses five kinds of input. Constant words at 0, 1024, 5000, 9999 and 14336 compare the long-run mean against the word: an exact multiple of 1024 shows that the error stays idle, and the other values show that fractions are carried correctly through both feedback taps. A sweeping pattern changes the word every cycle, which exposes a wrong delay or coefficient on either tap that a constant input can hide. A full-scale word drives the sum past the top, and a drop from a high word to zero drives it below zero. Together these separate clamping with full-error feedback from wrap-around or from feeding back only the low bits. A run, a reset and an identical rerun must produce the same stream, which shows that the error terms are cleared.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  // Extra integer bits carried by the internal sum so that 2*e1 - e2 never wraps.
  localparam int GUARD_W = 2;

  // How the quantizer resolved the current sum.
  typedef enum logic [1:0] {
    QZ_PASS = 2'd0,
    QZ_HIGH = 2'd1,
    QZ_LOW  = 2'd2
  } qz_state_e;
endpackage

// File: rtl/dsm2_quant.sv
module dsm2_quant #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 4,
  parameter int SUM_W = 17
) (
  input  logic signed [SUM_W-1:0] sum_v,
  output logic [OUT_W-1:0]        lvl,
  output logic signed [SUM_W-1:0] err,
  output dsm2_pkg::qz_state_e     state
);
  localparam int FRAC_W = IN_W - OUT_W;
  localparam logic signed [SUM_W-1:0] FULL = SUM_W'((1 << IN_W) - 1);

  logic signed [SUM_W-1:0] scaled;

  always_comb begin
    if (sum_v[SUM_W-1]) begin
      lvl   = '0;
      state = dsm2_pkg::QZ_LOW;
    end else if (sum_v > FULL) begin
      lvl   = '1;
      state = dsm2_pkg::QZ_HIGH;
    end else begin
      lvl   = sum_v[IN_W-1:FRAC_W];
      state = dsm2_pkg::QZ_PASS;
    end
    scaled = '0;
    scaled[IN_W-1:FRAC_W] = lvl;
    // Full difference, so that a clamped sample keeps its whole excess in the loop.
    err = sum_v - scaled;
  end
endmodule

// File: rtl/dsm2_err_fb.sv
module dsm2_err_fb #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 4,
  parameter int SUM_W = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         word,
  output logic [OUT_W-1:0]        lvl_next,
  output dsm2_pkg::qz_state_e     qz_state,
  output logic signed [SUM_W-1:0] err_now
);
  logic signed [SUM_W-1:0] err_d1;
  logic signed [SUM_W-1:0] err_d2;
  logic signed [SUM_W-1:0] word_ext;
  logic signed [SUM_W-1:0] sum_v;

  assign word_ext = $signed({{(SUM_W-IN_W){1'b0}}, word});
  // Error feedback 2z^-1 - z^-2 gives the noise transfer (1 - z^-1)^2.
  assign sum_v    = word_ext + (err_d1 <<< 1) - err_d2;

  dsm2_quant #(.IN_W(IN_W), .OUT_W(OUT_W), .SUM_W(SUM_W)) u_quant (
    .sum_v (sum_v),
    .lvl   (lvl_next),
    .err   (err_now),
    .state (qz_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_d1 <= '0;
      err_d2 <= '0;
    end else begin
      err_d1 <= err_now;
      err_d2 <= err_d1;
    end
  end
endmodule

// File: rtl/dsm2_therm_dec.sv
module dsm2_therm_dec #(
  parameter int OUT_W = 4,
  parameter int LINES = 15
) (
  input  logic [OUT_W-1:0] lvl,
  output logic [LINES-1:0] lines
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign lines[k] = (lvl > OUT_W'(k));
  end
endmodule

// File: rtl/dsm2_therm_dac.sv
module dsm2_therm_dac #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 4,
  localparam int LINES = (1 << OUT_W) - 1,
  localparam int SUM_W = IN_W + 1 + dsm2_pkg::GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  ctrl_word,
  output logic [OUT_W-1:0] level,
  output logic [LINES-1:0] therm
);
  logic [OUT_W-1:0]        lvl_next;
  logic [LINES-1:0]        therm_next;
  dsm2_pkg::qz_state_e     qz_state;
  logic signed [SUM_W-1:0] err_now;

  dsm2_err_fb #(.IN_W(IN_W), .OUT_W(OUT_W), .SUM_W(SUM_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .word     (ctrl_word),
    .lvl_next (lvl_next),
    .qz_state (qz_state),
    .err_now  (err_now)
  );

  dsm2_therm_dec #(.OUT_W(OUT_W), .LINES(LINES)) u_dec (
    .lvl   (lvl_next),
    .lines (therm_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      therm <= '0;
    end else begin
      level <= lvl_next;
      therm <= therm_next;
    end
  end
endmodule

// File: rtl/dsm2_therm_dac_chk.sv
module dsm2_therm_dac_chk #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 4,
  parameter int LINES = 15,
  parameter int SUM_W = 17
) (
  input logic                    clk,
  input logic                    rst,
  input logic [OUT_W-1:0]        level,
  input logic [LINES-1:0]        therm,
  input dsm2_pkg::qz_state_e     qz_state,
  input logic signed [SUM_W-1:0] err_now
);
  localparam int FRAC_W = IN_W - OUT_W;

  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  // R1: the edge after a reset edge shows cleared outputs.
  always @(posedge clk) begin
    if (was_rst === 1'b1) begin
      p_reset_clear_r1: assert (level == '0 && therm == '0)
        else $error("reset did not clear outputs");
    end
  end

  p_sat_high_r5: assert property (@(posedge clk) disable iff (rst)
    (qz_state == dsm2_pkg::QZ_HIGH) |=> (level == '1));

  p_sat_low_r5: assert property (@(posedge clk) disable iff (rst)
    (qz_state == dsm2_pkg::QZ_LOW) |=> (level == '0));

  p_err_range_r4: assert property (@(posedge clk) disable iff (rst)
    (qz_state == dsm2_pkg::QZ_PASS) |->
      (!err_now[SUM_W-1] && err_now < SUM_W'(1 << FRAC_W)));

  p_therm_count_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(therm) == int'(level)));

  p_therm_shape_r7: assert property (@(posedge clk) disable iff (rst)
    (((therm + 1'b1) & therm) == '0));
endmodule

bind dsm2_therm_dac dsm2_therm_dac_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .LINES(LINES), .SUM_W(SUM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .level    (level),
  .therm    (therm),
  .qz_state (qz_state),
  .err_now  (err_now)
);

// File: tb/tb_dsm2_therm_dac.sv
module tb_dsm2_therm_dac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [3:0]  level;
  logic [14:0] therm;

  dsm2_therm_dac dut (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .level     (level),
    .therm     (therm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  lvl;
    logic [14:0] th;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int m_e1 = 0;
  int m_e2 = 0;
  int acc_sum = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Driver: applies one word and pushes the expected output built from R3, R4, R5 and R6.
  task automatic step(input int x);
    int s, y, e;
    exp_t it;
    @(negedge clk);
    ctrl_word = 14'(x);
    s = x + 2 * m_e1 - m_e2;
    if (s > 16383) begin
      y = 15; it.tag = "R5";
    end else if (s < 0) begin
      y = 0;  it.tag = "R5";
    end else begin
      y = s / 1024; it.tag = "R4";
    end
    e = s - y * 1024;
    m_e2 = m_e1;
    m_e1 = e;
    it.lvl = 4'(y);
    for (int k = 0; k < 15; k++) it.th[k] = (y > k);
    sb_q.push_back(it);
  endtask

  // Monitor: samples just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(level == it.lvl, it.tag, int'(level), int'(it.lvl));
      check(therm == it.th, "R6", int'(therm), int'(it.th));
      check(((therm + 1'b1) & therm) == '0, "R7", int'(therm), 0);
      acc_sum += int'(level);
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk);
    ctrl_word = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(level == 4'd0, "R1", int'(level), 0);
    check(therm == 15'd0, "R1", int'(therm), 0);
    rst = 1'b0;
    m_e1 = 0;
    m_e2 = 0;
  endtask

  task automatic mean_case(input int x);
    do_reset();
    acc_sum = 0;
    repeat (1024) step(x);
    drain();
    check((acc_sum - x) <= 1 && (acc_sum - x) >= -1, "R8", acc_sum, x);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    // R2: first word applied; the output must not move before the next edge.
    step(3072);
    check(level == 4'd0, "R2", int'(level), 0);
    repeat (5) step(3072);

    // Sweeping input: exercises both feedback taps (R3).
    for (int i = 0; i < 200; i++) step(1023 + (i * 677) % 13000);

    // R1: run, reset, rerun must give an identical stream (scoreboard model restarts from zero).
    repeat (37) step(7777);
    do_reset();
    repeat (37) step(7777);

    // R5: full-scale word clamps high with full error feedback.
    do_reset();
    repeat (6) step(16383);

    // R5: drop from a high word to zero drives the sum negative.
    do_reset();
    repeat (41) step(14000);
    repeat (6) step(0);

    // R8: long-run mean for several constant words.
    mean_case(0);
    mean_case(1024);
    mean_case(5000);
    mean_case(9999);
    mean_case(14336);

    drain();
    report();
  end
endmodule